// File: doc/BRIEF.md
# External Interrupt Sensitivity Controller

This block turns two byte-wide groups of external interrupt pins into one pending interrupt request per group. Each group has a 2-bit sensitivity code. The code selects one of four trigger conditions: rising edges, falling edges, both edges, or a falling edge combined with a held-low level. Every pin passes through a two-stage synchroniser. The block then compares the synchronised value with the sample from the previous cycle to find edges.

An 8-bit control register holds both sensitivity codes and four general bits that software may use freely. Software writes the codes, but the block accepts a change to them only while the CPU reports its highest interrupt-mask level. A write at any lower level leaves the codes unchanged, and the free bits still take the written value. The CPU clears a group's request with a one-cycle acknowledge pulse. In the level-sensitive mode the request comes back while any pin of the group is still low.

Top module: `xint_sense_ctrl`

## Requirements
- R1: While reset is active and after reset, the control register reads 0x00 and both requests are 0.
- R2: Register bits 5, 2, 1 and 0 take the written value on every write, whatever the mask level.
- R3: Bits 7:6 (group A code) and bits 4:3 (group B code) change on a write only when `imask_lvl` is 2'b11. Otherwise they keep their old value.
- R4: With code 2'b01 a rising edge on any pin sets the request, and a falling edge does not.
- R5: With code 2'b10 a falling edge on any pin sets the request, and a rising edge does not.
- R6: With code 2'b11 both rising and falling edges set the request.
- R7: With code 2'b00 the request is set while any pin of the group is low. An acknowledge clears it for exactly one cycle if a pin is still low. After all pins are high, an acknowledge clears it for good.
- R8: A set request stays 1 until an acknowledge for that group. The request reads 0 in the cycle after the acknowledge when no new event occurs.
- R9: A new event that is detected in the same cycle as an acknowledge leaves the request at 1.
- R10: The two groups are independent. Events on one group's pins never set the other group's request.
- R11: A pin change becomes visible on the request output after the third rising clock edge. The request is still 0 after the second edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Current control register value |
| imask_lvl | input | 2 | CPU interrupt-mask bits; 2'b11 unlocks the sensitivity codes |
| pins_a | input | PIN_W | Group A external interrupt pins (idle high) |
| pins_b | input | PIN_W | Group B external interrupt pins (idle high) |
| irq_ack | input | 2 | Per-group acknowledge pulse (bit 0 = A, bit 1 = B) |
| irq_req | output | 2 | Per-group pending request (bit 0 = A, bit 1 = B) |

## Verification
Each sensitivity code is driven with a falling transition followed by a rising transition on a single pin. This pattern tells the rising-only, falling-only and both-edges modes apart, because each mode must answer to a different half of the pair. The level mode is driven with a pin held low across acknowledges, which separates a true level trigger from a latched edge. An edge timed to land on the acknowledge cycle shows whether a new event can be lost. Writes at mask levels below and at the maximum show that the codes are locked and the free bits are not.

// File: rtl/xint_pkg.sv
package xint_pkg;

  localparam int NUM_GRP = 2;
  localparam int REG_W   = 8;

  localparam logic [1:0] MASK_TOP = 2'b11;

  typedef enum logic [1:0] {
    SENSE_LOW_FALL = 2'b00,
    SENSE_RISE     = 2'b01,
    SENSE_FALL     = 2'b10,
    SENSE_BOTH     = 2'b11
  } sense_e;

  // Lowest bit of the sensitivity field of group g.
  function automatic int field_lsb(input int g);
    return (g == 0) ? 6 : 3;
  endfunction

  function automatic logic [REG_W-1:0] field_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      m[field_lsb(g)]     = 1'b1;
      m[field_lsb(g) + 1] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [REG_W-1:0] LOCK_MASK = field_mask();
  localparam logic [REG_W-1:0] FREE_MASK = ~field_mask();

endpackage

// File: rtl/xint_rst_sync.sv
module xint_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/xint_pin_sync.sv
module xint_pin_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_s
);

  // Pins idle high, so both stages come out of reset high.
  localparam logic [W-1:0] IDLE = '1;

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= IDLE;
      sync_q <= IDLE;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
    end
  end

  assign pin_s = sync_q;

endmodule

// File: rtl/xint_ctrl_reg.sv
module xint_ctrl_reg
  import xint_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [REG_W-1:0]       wdata,
  input  logic [1:0]             imask_lvl,
  output logic [REG_W-1:0]       ctrl_o,
  output logic [NUM_GRP-1:0][1:0] sense_o,
  output logic [NUM_GRP-1:0]     chg_o
);

  logic [REG_W-1:0]   ctrl_q, ctrl_d;
  logic [REG_W-1:0]   wmask;
  logic               unlock;
  logic [NUM_GRP-1:0] chg_q, chg_d;

  always_comb begin
    unlock = (imask_lvl == MASK_TOP);
    wmask  = FREE_MASK | (unlock ? LOCK_MASK : '0);
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d = (ctrl_q & ~wmask) | (wdata & wmask);
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_fld
    localparam int LSB = field_lsb(g);
    assign chg_d[g]   = (ctrl_d[LSB +: 2] != ctrl_q[LSB +: 2]);
    assign sense_o[g] = ctrl_q[LSB +: 2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      chg_q  <= '0;
    end else begin
      if (wr_en) begin
        ctrl_q <= ctrl_d;
      end
      chg_q <= chg_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign chg_o  = chg_q;

endmodule

// File: rtl/xint_grp_detect.sv
module xint_grp_detect
  import xint_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    sense,
  input  logic          reload,
  input  logic [PW-1:0] pins_s,
  input  logic          ack,
  output logic          req
);

  localparam logic [PW-1:0] IDLE = '1;

  logic [PW-1:0] prev_q;
  logic          pend_q, pend_d, pend_en;
  logic          any_rise, any_fall, any_low;
  logic          evt;

  always_comb begin
    // An edge seen in the cycle right after a code change is compared
    // against the old baseline, so it is suppressed.
    any_rise = (|(pins_s & ~prev_q)) & ~reload;
    any_fall = (|(~pins_s & prev_q)) & ~reload;
    any_low  = |(~pins_s);
    unique case (sense_e'(sense))
      SENSE_LOW_FALL: evt = any_low;
      SENSE_RISE:     evt = any_rise;
      SENSE_FALL:     evt = any_fall;
      SENSE_BOTH:     evt = any_rise | any_fall;
      default:        evt = 1'b0;
    endcase
  end

  always_comb begin
    pend_en = evt | ack;
    if (sense_e'(sense) == SENSE_LOW_FALL) begin
      pend_d = ack ? 1'b0 : (pend_q | evt);
    end else begin
      pend_d = (pend_q & ~ack) | evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= IDLE;
      pend_q <= 1'b0;
    end else begin
      prev_q <= pins_s;
      if (pend_en) begin
        pend_q <= pend_d;
      end
    end
  end

  assign req = pend_q;

endmodule

// File: rtl/xint_sense_ctrl.sv
module xint_sense_ctrl
  import xint_pkg::*;
#(
  parameter int PIN_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic [1:0]         imask_lvl,
  input  logic [PIN_W-1:0]   pins_a,
  input  logic [PIN_W-1:0]   pins_b,
  input  logic [NUM_GRP-1:0] irq_ack,
  output logic [NUM_GRP-1:0] irq_req
);

  logic                            rst_sync_n;
  logic [NUM_GRP-1:0][1:0]         sense;
  logic [NUM_GRP-1:0]              chg;
  logic [NUM_GRP-1:0][PIN_W-1:0]   pins_raw;
  logic [NUM_GRP-1:0][PIN_W-1:0]   pins_s;

  assign pins_raw = {pins_b, pins_a};

  xint_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  xint_ctrl_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (reg_wr),
    .wdata     (reg_wdata),
    .imask_lvl (imask_lvl),
    .ctrl_o    (reg_rdata),
    .sense_o   (sense),
    .chg_o     (chg)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    xint_pin_sync #(.W(PIN_W)) u_sync (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .pin_i (pins_raw[g]),
      .pin_s (pins_s[g])
    );

    xint_grp_detect #(.PW(PIN_W)) u_det (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .sense  (sense[g]),
      .reload (chg[g]),
      .pins_s (pins_s[g]),
      .ack    (irq_ack[g]),
      .req    (irq_req[g])
    );
  end

endmodule

// File: rtl/xint_sense_chk.sv
module xint_sense_chk
  import xint_pkg::*;
(
  input logic               clk,
  input logic               rst_q_n,
  input logic               reg_wr,
  input logic [REG_W-1:0]   reg_wdata,
  input logic [REG_W-1:0]   reg_rdata,
  input logic [1:0]         imask_lvl,
  input logic [NUM_GRP-1:0] irq_ack,
  input logic [NUM_GRP-1:0] irq_req
);

  p_free_bits_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    reg_wr |=> (reg_rdata & FREE_MASK) == ($past(reg_wdata) & FREE_MASK));

  p_locked_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (reg_wr && imask_lvl != MASK_TOP) |=>
      (reg_rdata & LOCK_MASK) == ($past(reg_rdata) & LOCK_MASK));

  p_unlocked_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (reg_wr && imask_lvl == MASK_TOP) |=>
      (reg_rdata & LOCK_MASK) == ($past(reg_wdata) & LOCK_MASK));

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_req
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
      (irq_req[g] && !irq_ack[g]) |=> irq_req[g]);
  end

endmodule

bind xint_sense_ctrl xint_sense_chk u_chk (
  .clk       (clk),
  .rst_q_n   (rst_sync_n),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .imask_lvl (imask_lvl),
  .irq_ack   (irq_ack),
  .irq_req   (irq_req)
);

// File: tb/xint_sense_ctrl_tb.sv
module xint_sense_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] imask_lvl = '0;
  logic [7:0] pins_a = '1;
  logic [7:0] pins_b = '1;
  logic [1:0] irq_ack = '0;
  logic [1:0] irq_req;

  int  cyc = 0;
  int  n_chk = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  typedef struct {
    int         at;
    bit         is_reg;
    int         grp;
    logic [7:0] val;
    string      tag;
  } exp_t;

  exp_t sb[$];

  xint_sense_ctrl u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .imask_lvl (imask_lvl),
    .pins_a    (pins_a),
    .pins_b    (pins_b),
    .irq_ack   (irq_ack),
    .irq_req   (irq_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Scoreboard insertion kept ordered by target cycle.
  task automatic push(input int at, input bit is_reg, input int grp,
                      input logic [7:0] val, input string tag);
    exp_t e;
    int   pos;
    e.at = at; e.is_reg = is_reg; e.grp = grp; e.val = val; e.tag = tag;
    pos = sb.size();
    for (int i = 0; i < sb.size(); i++) begin
      if (sb[i].at > at) begin
        pos = i;
        break;
      end
    end
    sb.insert(pos, e);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Monitor: pops expected items when their cycle is reached.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      if (e.is_reg) check(e.tag, reg_rdata, e.val);
      else          check(e.tag, {7'd0, irq_req[e.grp]}, e.val);
    end
  end

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v, input logic [1:0] lvl,
                    input logic [7:0] exp, input string tag);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = v; imask_lvl = lvl;
    push(cyc + 1, 1'b1, 0, exp, tag);
    @(negedge clk);
    reg_wr = 1'b0; imask_lvl = 2'b00;
    drain();
  endtask

  task automatic set_pins(input int g, input logic [7:0] v, output int at);
    @(negedge clk);
    if (g == 0) pins_a = v;
    else        pins_b = v;
    at = cyc;
  endtask

  task automatic pulse_ack(input int g, output int at);
    @(negedge clk);
    irq_ack[g] = 1'b1;
    at = cyc;
    @(negedge clk);
    irq_ack[g] = 1'b0;
  endtask

  task automatic exp_req(input int at, input int g, input bit v, input string tag);
    push(at, 1'b0, g, {7'd0, v}, tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int t, m;
    repeat (3) @(negedge clk);
    check("R1 reset rdata", reg_rdata, 8'h00);
    check("R1 reset req", {6'd0, irq_req}, 8'h00);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 after reset rdata", reg_rdata, 8'h00);
    check("R1 after reset req", {6'd0, irq_req}, 8'h00);

    // R2 / R3: locked writes only touch the free bits
    wr(8'hFF, 2'b01, 8'h27, "R2 free bits at level 01");
    wr(8'hFF, 2'b10, 8'h27, "R3 codes locked at level 10");
    // A = 01 rising, B = 10 falling
    wr(8'h50, 2'b11, 8'h50, "R3 codes written at level 11");

    // R4: group A rising only
    set_pins(0, 8'hF7, t);
    exp_req(t + 3, 0, 1'b0, "R4 falling ignored");
    exp_req(t + 5, 0, 1'b0, "R4 falling ignored later");
    drain();
    set_pins(0, 8'hFF, t);
    exp_req(t + 2, 0, 1'b0, "R11 not yet after two edges");
    exp_req(t + 3, 0, 1'b1, "R11 visible after third edge");
    exp_req(t + 3, 1, 1'b0, "R10 group B untouched by A");
    exp_req(t + 8, 0, 1'b1, "R8 request held");
    drain();
    pulse_ack(0, m);
    exp_req(m + 1, 0, 1'b0, "R8 ack clears");
    exp_req(m + 3, 0, 1'b0, "R8 stays clear");
    drain();

    // R5: group B falling only
    set_pins(1, 8'h7F, t);
    exp_req(t + 3, 1, 1'b1, "R5 falling sets");
    exp_req(t + 3, 0, 1'b0, "R10 group A untouched by B");
    drain();
    pulse_ack(1, m);
    exp_req(m + 1, 1, 1'b0, "R5 ack clears");
    drain();
    set_pins(1, 8'hFF, t);
    exp_req(t + 3, 1, 1'b0, "R5 rising ignored");
    exp_req(t + 5, 1, 1'b0, "R5 rising ignored later");
    drain();

    // R6: both edges on both groups
    wr(8'hD8, 2'b11, 8'hD8, "R6 both-edge codes");
    set_pins(0, 8'hFE, t);
    exp_req(t + 3, 0, 1'b1, "R6 falling sets");
    drain();
    pulse_ack(0, m);
    exp_req(m + 1, 0, 1'b0, "R6 ack clears");
    drain();
    set_pins(0, 8'hFF, t);
    exp_req(t + 3, 0, 1'b1, "R6 rising sets");
    drain();
    pulse_ack(0, m);
    exp_req(m + 1, 0, 1'b0, "R6 ack clears again");
    drain();

    // R9: edge coincides with ack
    set_pins(1, 8'hFB, t);
    exp_req(t + 3, 1, 1'b1, "R9 first event sets");
    drain();
    set_pins(1, 8'hFF, t);
    @(negedge clk);
    @(negedge clk);
    irq_ack[1] = 1'b1;
    @(negedge clk);
    irq_ack[1] = 1'b0;
    exp_req(t + 4, 1, 1'b1, "R9 request kept through ack");
    exp_req(t + 6, 1, 1'b1, "R9 request still kept");
    drain();
    pulse_ack(1, m);
    exp_req(m + 1, 1, 1'b0, "R9 later ack clears");
    drain();

    // R7: group A level / falling mode
    wr(8'h18, 2'b11, 8'h18, "R7 level code on group A");
    set_pins(0, 8'hDF, t);
    exp_req(t + 2, 0, 1'b0, "R7 not yet");
    exp_req(t + 3, 0, 1'b1, "R7 low sets");
    exp_req(t + 6, 0, 1'b1, "R7 low holds");
    drain();
    pulse_ack(0, m);
    exp_req(m + 1, 0, 1'b0, "R7 ack drops one cycle");
    exp_req(m + 2, 0, 1'b1, "R7 reasserts while low");
    drain();
    set_pins(0, 8'hFF, t);
    repeat (4) @(negedge clk);
    exp_req(cyc, 0, 1'b1, "R7 latched after release");
    drain();
    pulse_ack(0, m);
    exp_req(m + 1, 0, 1'b0, "R7 ack clears when high");
    exp_req(m + 3, 0, 1'b0, "R7 stays clear when high");
    drain();

    // R3: lock again, free bits still written
    wr(8'hC7, 2'b10, 8'h1F, "R3 codes locked again");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule